// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Port-A Interrupts

This block is a general-purpose I/O controller behind an APB slave. It has up to four 32-line ports. Each port has an output-value register, an output-enable register and a read-only view of its pins. A port's output value and output enable go straight to the pad ring. Every pin passes through a two-flop synchronizer before any logic or bus read sees it.

Port A also has interrupt logic for each line. Software can enable or mask each line, choose edge or level detection, and choose the polarity. Edge events latch until software writes a one to the clear register. Any port-A line can be given a slow two-sample filter that runs on an internal tick, one tick every `DEB_DIV` clocks. The block drives one combined interrupt and one output for each port-A line. A build-time parameter moves part of the interrupt register set to a second offset map. Both-edge detection is not built into the hardware: software gets it by flipping the polarity after each event.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset every register reads 0, all pad outputs and output enables are 0, and no interrupt output is active.
- R2: Port p (p = 0..NUM_PORTS-1) has an output-value register at byte offset 12*p and an output-enable register at 12*p+4. Both read back what was written and drive `pad_out_o` and `pad_oe_o` bits 32*p..32*p+31.
- R3: The read-only pin register of port p is at 0x50+4*p. It returns the pins through two flops: a change on `pins_i` shows on the second rising clock edge after it. This value is never filtered.
- R4: With `ALT_MAP`=0 the port-A interrupt registers are: enable 0x30, mask 0x34, type 0x38, polarity 0x3c, status 0x40 (read-only), filter select 0x48, and clear 0x4c (write-only, reads 0).
- R5: With `ALT_MAP`=1 the offsets are: type 0x34, polarity 0x38, status 0x3c, clear 0x40, mask 0x44. Enable (0x30) and filter select (0x48) do not move.
- R6: A type bit of 1 selects edge detection. A polarity bit of 1 selects the rising edge and 0 the falling edge. A detected edge latches one clock edge after the synchronized pin changes. It stays latched until a clear write with a 1 in that bit. Clear bits written as 0 have no effect.
- R7: A type bit of 0 selects level detection. The line is active while its source equals its polarity bit (1 = active high, 0 = active low). Clear writes do not affect it.
- R8: A mask bit of 1 hides the line from status and outputs, but a latched edge is kept and shows once the mask bit is cleared. An enable bit of 0 blocks detection and drops any latched edge.
- R9: Status = pending AND enable AND NOT mask. `irq_line_o` equals status, and `irq_o` is the OR of its bits.
- R10: A port-A line with its filter-select bit set feeds the interrupt logic only with a value that was present at two consecutive ticks, one tick every `DEB_DIV` clocks. A pulse no longer than `DEB_DIV` cycles is never seen.
- R11: Reads of unmapped offsets, or of registers of ports above NUM_PORTS-1, return 0. Writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | 7 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always 1 |
| pins_i | input | NUM_PORTS*32 | Pin values from the pads |
| pad_out_o | output | NUM_PORTS*32 | Output value to the pads |
| pad_oe_o | output | NUM_PORTS*32 | Output enable to the pads |
| irq_o | output | 1 | Combined interrupt |
| irq_line_o | output | 32 | Interrupt output for each port-A line |

## Verification
The bench goes after the edge-clear race and the clear-mask semantics. A design that cleared on written zeros would lose pending lines. One that let clear writes reach level lines would drop an active level.

It also tests a masked edge that must come back after unmasking, and a disable that must discard a latched event. A design that gated the latch with the mask would lose the event. One that kept latching while disabled would raise a stale interrupt on re-enable.

Filtered lines get a pulse shorter than one tick period. A one-sample filter would let that pulse through, while the unfiltered pin register must still show it. The alternate map is read back at every moved offset, and an absent port is written and then read, so a decode slip shows up as a wrong read value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned MAX_PORTS  = 4;
  localparam int unsigned PORT_IDX_W = 2;
  localparam int unsigned PAIR_STEP  = 12;
  localparam int unsigned PIN_BASE   = 'h50;
  localparam int unsigned PIN_STEP   = 4;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DR, SEL_DDR, SEL_PIN, SEL_EN, SEL_MASK,
    SEL_TYPE, SEL_POL, SEL_STAT, SEL_FILT, SEL_CLR
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e              sel;
    logic [PORT_IDX_W-1:0] port;
  } dec_t;

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input bit alt,
                                       input int unsigned nports);
    dec_t d;
    d.sel  = SEL_NONE;
    d.port = '0;
    for (int p = 0; p < int'(MAX_PORTS); p++) begin
      if (p < int'(nports)) begin
        if (a == ADDR_W'(p * PAIR_STEP)) begin
          d.sel = SEL_DR;  d.port = PORT_IDX_W'(p);
        end
        if (a == ADDR_W'(p * PAIR_STEP + 4)) begin
          d.sel = SEL_DDR; d.port = PORT_IDX_W'(p);
        end
        if (a == ADDR_W'(PIN_BASE + p * PIN_STEP)) begin
          d.sel = SEL_PIN; d.port = PORT_IDX_W'(p);
        end
      end
    end
    if (a == ADDR_W'('h30)) d.sel = SEL_EN;
    if (a == ADDR_W'('h48)) d.sel = SEL_FILT;
    if (alt) begin
      case (a)
        ADDR_W'('h34): d.sel = SEL_TYPE;
        ADDR_W'('h38): d.sel = SEL_POL;
        ADDR_W'('h3c): d.sel = SEL_STAT;
        ADDR_W'('h40): d.sel = SEL_CLR;
        ADDR_W'('h44): d.sel = SEL_MASK;
        default: ;
      endcase
    end else begin
      case (a)
        ADDR_W'('h34): d.sel = SEL_MASK;
        ADDR_W'('h38): d.sel = SEL_TYPE;
        ADDR_W'('h3c): d.sel = SEL_POL;
        ADDR_W'('h40): d.sel = SEL_STAT;
        ADDR_W'('h4c): d.sel = SEL_CLR;
        default: ;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_filter.sv
module gpio_filter #(
  parameter int unsigned W   = 32,
  parameter int unsigned DIV = 1024
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic tick;

  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      assign tick = (cnt_q == CW'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  logic [W-1:0] samp_q, out_q, agree;
  assign agree = ~(d_i ^ samp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      out_q  <= '0;
    end else if (tick) begin
      samp_q <= d_i;
      out_q  <= (agree & d_i) | (~agree & out_q);
    end
  end

  assign q_o = out_q;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] type_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, pend_q, hit, lvl, raw;

  // polarity 1 = rising, 0 = falling
  assign hit = (pol_i & src_i & ~prev_q) | (~pol_i & ~src_i & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= src_i;
      pend_q <= en_i & type_i & ((pend_q & ~clr_i) | hit);
    end
  end

  assign lvl      = ~(src_i ^ pol_i);
  assign raw      = (type_i & pend_q) | (~type_i & lvl);
  assign status_o = raw & en_i & ~mask_i;
  assign pend_o   = pend_q;
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter bit          ALT_MAP   = 1'b0,
  parameter int unsigned DEB_DIV   = 1024
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        psel_i,
  input  logic                        penable_i,
  input  logic                        pwrite_i,
  input  logic [ADDR_W-1:0]           paddr_i,
  input  logic [DATA_W-1:0]           pwdata_i,
  output logic [DATA_W-1:0]           prdata_o,
  output logic                        pready_o,
  input  logic [NUM_PORTS*DATA_W-1:0] pins_i,
  output logic [NUM_PORTS*DATA_W-1:0] pad_out_o,
  output logic [NUM_PORTS*DATA_W-1:0] pad_oe_o,
  output logic                        irq_o,
  output logic [DATA_W-1:0]           irq_line_o
);
  localparam int unsigned PW = NUM_PORTS * DATA_W;

  dec_t dec;
  logic wr_en;
  assign dec   = decode_addr(paddr_i, ALT_MAP, NUM_PORTS);
  assign wr_en = psel_i & penable_i & pwrite_i;

  logic [DATA_W-1:0] dr_q  [NUM_PORTS];
  logic [DATA_W-1:0] ddr_q [NUM_PORTS];
  logic [PW-1:0]     pins_sync;

  generate
    for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dr_q[p]  <= '0;
          ddr_q[p] <= '0;
        end else if (wr_en && dec.port == PORT_IDX_W'(p)) begin
          if (dec.sel == SEL_DR)  dr_q[p]  <= pwdata_i;
          if (dec.sel == SEL_DDR) ddr_q[p] <= pwdata_i;
        end
      end
      assign pad_out_o[p*DATA_W +: DATA_W] = dr_q[p];
      assign pad_oe_o[p*DATA_W +: DATA_W]  = ddr_q[p];
    end
  endgenerate

  logic [DATA_W-1:0] en_q, mask_q, type_q, pol_q, filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
      filt_q <= '0;
    end else if (wr_en) begin
      case (dec.sel)
        SEL_EN:   en_q   <= pwdata_i;
        SEL_MASK: mask_q <= pwdata_i;
        SEL_TYPE: type_q <= pwdata_i;
        SEL_POL:  pol_q  <= pwdata_i;
        SEL_FILT: filt_q <= pwdata_i;
        default: ;
      endcase
    end
  end

  logic [DATA_W-1:0] eoi_clr;
  assign eoi_clr = (wr_en && dec.sel == SEL_CLR) ? pwdata_i : '0;

  gpio_sync #(.W(PW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_sync)
  );

  logic [DATA_W-1:0] filt_val, irq_src, pend_a, status;

  gpio_filter #(.W(DATA_W), .DIV(DEB_DIV)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_sync[DATA_W-1:0]),
    .q_o   (filt_val)
  );

  assign irq_src = (filt_q & filt_val) | (~filt_q & pins_sync[DATA_W-1:0]);

  gpio_irq #(.W(DATA_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (irq_src),
    .en_i    (en_q),
    .mask_i  (mask_q),
    .type_i  (type_q),
    .pol_i   (pol_q),
    .clr_i   (eoi_clr),
    .pend_o  (pend_a),
    .status_o(status)
  );

  assign irq_line_o = status;
  assign irq_o      = |status;

  logic [DATA_W-1:0] rd;
  always_comb begin
    rd = '0;
    for (int p = 0; p < int'(NUM_PORTS); p++) begin
      if (dec.port == PORT_IDX_W'(p)) begin
        if (dec.sel == SEL_DR)  rd = dr_q[p];
        if (dec.sel == SEL_DDR) rd = ddr_q[p];
        if (dec.sel == SEL_PIN) rd = pins_sync[p*DATA_W +: DATA_W];
      end
    end
    case (dec.sel)
      SEL_EN:   rd = en_q;
      SEL_MASK: rd = mask_q;
      SEL_TYPE: rd = type_q;
      SEL_POL:  rd = pol_q;
      SEL_STAT: rd = status;
      SEL_FILT: rd = filt_q;
      default: ;
    endcase
  end

  assign prdata_o = (psel_i && !pwrite_i) ? rd : '0;
  assign pready_o = 1'b1;
endmodule

// File: rtl/gpio_apb_ctrl_chk.sv
module gpio_apb_ctrl_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_PORTS*DATA_W-1:0] pins_i,
  input logic [NUM_PORTS*DATA_W-1:0] pins_sync,
  input logic [DATA_W-1:0]           en_q,
  input logic [DATA_W-1:0]           mask_q,
  input logic [DATA_W-1:0]           type_q,
  input logic [DATA_W-1:0]           pend_a,
  input logic [DATA_W-1:0]           eoi_clr,
  input logic [DATA_W-1:0]           irq_line_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= '0;
    else if (cyc_q != 2'd2)  cyc_q <= cyc_q + 1'b1;
  end

  // R3: pin view lags the pads by exactly two clocks
  a_r3_two_flop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (pins_sync == $past(pins_i, 2)));

  // R8: masked lines never reach the outputs
  a_r8_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_line_o & mask_q) == '0));

  // R8: disabled lines never reach the outputs
  a_r8_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_line_o & ~en_q) == '0));

  // R6: a latched edge survives until cleared or disabled
  a_r6_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_a & en_q & type_q & ~eoi_clr) & ~pend_a) == '0));
endmodule

bind gpio_apb_ctrl gpio_apb_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(gpio_pkg::DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pins_i    (pins_i),
  .pins_sync (pins_sync),
  .en_q      (en_q),
  .mask_q    (mask_q),
  .type_q    (type_q),
  .pend_a    (pend_a),
  .eoi_clr   (eoi_clr),
  .irq_line_o(irq_line_o)
);

// File: tb/tb_gpio_apb_ctrl.sv
module tb_gpio_apb_ctrl;
  localparam int NP  = 4;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic psel = 0, psel_alt = 0, penable = 0, pwrite = 0;
  logic [6:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_alt;
  logic pready, pready_alt;
  logic [NP*32-1:0] pins = '0;
  logic [NP*32-1:0] pad_out, pad_oe;
  logic irq, irq_alt;
  logic [31:0] irq_line, irq_line_alt;
  logic [63:0] pins_alt = '0;
  logic [63:0] pad_out_alt, pad_oe_alt;

  gpio_apb_ctrl #(.NUM_PORTS(NP), .ALT_MAP(1'b0), .DEB_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pins_i(pins), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq), .irq_line_o(irq_line));

  gpio_apb_ctrl #(.NUM_PORTS(2), .ALT_MAP(1'b1), .DEB_DIV(DIV)) dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel_alt), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata_alt), .pready_o(pready_alt),
    .pins_i(pins_alt), .pad_out_o(pad_out_alt), .pad_oe_o(pad_oe_alt), .irq_o(irq_alt),
    .irq_line_o(irq_line_alt));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_dr [NP];
  logic [31:0] m_ddr [NP];
  logic [31:0] m_en, m_mask, m_type, m_pol, m_filt;
  logic [NP*32-1:0] m_s1, m_s2;
  logic [31:0] m_samp, m_fout, m_prev, m_pend;
  int m_cnt;

  function automatic logic [31:0] m_src();
    logic [31:0] s;
    for (int i = 0; i < 32; i++) s[i] = m_filt[i] ? m_fout[i] : m_s2[i];
    return s;
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] s, src;
    src = m_src();
    for (int i = 0; i < 32; i++) begin
      if (!m_en[i] || m_mask[i]) s[i] = 1'b0;
      else if (m_type[i])        s[i] = m_pend[i];
      else                       s[i] = (src[i] == m_pol[i]);
    end
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_dr[p] = 0; m_ddr[p] = 0; end
      m_en = 0; m_mask = 0; m_type = 0; m_pol = 0; m_filt = 0;
      m_s1 = 0; m_s2 = 0; m_samp = 0; m_fout = 0; m_prev = 0; m_pend = 0; m_cnt = 0;
    end else begin
      logic [31:0] src, clr, a;
      bit w;
      w   = psel && penable && pwrite;
      src = m_src();
      clr = (w && paddr == 7'h4c) ? pwdata : 32'h0;
      for (int i = 0; i < 32; i++) begin
        bit edge_seen;
        edge_seen = m_pol[i] ? (src[i] && !m_prev[i]) : (!src[i] && m_prev[i]);
        if (!(m_en[i] && m_type[i])) m_pend[i] = 1'b0;
        else if (edge_seen)          m_pend[i] = 1'b1;
        else if (clr[i])             m_pend[i] = 1'b0;
      end
      m_prev = src;
      if (m_cnt == DIV - 1) begin
        a = m_s2[31:0];
        for (int i = 0; i < 32; i++) if (a[i] == m_samp[i]) m_fout[i] = a[i];
        m_samp = a;
        m_cnt = 0;
      end else m_cnt++;
      m_s2 = m_s1;
      m_s1 = pins;
      if (w) begin
        for (int p = 0; p < NP; p++) begin
          if (paddr == 7'(12*p))     m_dr[p]  = pwdata;
          if (paddr == 7'(12*p + 4)) m_ddr[p] = pwdata;
        end
        case (paddr)
          7'h30: m_en = pwdata;
          7'h34: m_mask = pwdata;
          7'h38: m_type = pwdata;
          7'h3c: m_pol = pwdata;
          7'h48: m_filt = pwdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [6:0] a);
    logic [31:0] r;
    r = 0;
    for (int p = 0; p < NP; p++) begin
      if (a == 7'(12*p))     r = m_dr[p];
      if (a == 7'(12*p + 4)) r = m_ddr[p];
      if (a == 7'(80 + 4*p)) r = m_s2[p*32 +: 32];
    end
    case (a)
      7'h30: r = m_en;
      7'h34: r = m_mask;
      7'h38: r = m_type;
      7'h3c: r = m_pol;
      7'h40: r = m_status();
      7'h48: r = m_filt;
      default: ;
    endcase
    return r;
  endfunction

  // per-clock comparison of pad and interrupt outputs (R2, R9)
  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp) begin
      logic [31:0] st;
      st = m_status();
      for (int p = 0; p < NP; p++) begin
        chk("R2 pad_out", pad_out[p*32 +: 32], m_dr[p]);
        chk("R2 pad_oe", pad_oe[p*32 +: 32], m_ddr[p]);
      end
      chk("R9 irq_line", irq_line, st);
      chk("R9 irq_o", {31'b0, irq}, {31'b0, |st});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic apb_wr(input bit alt, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = !alt; psel_alt = alt; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; psel_alt = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input bit alt, input logic [6:0] a, output logic [31:0] d,
                        output logic [31:0] e);
    @(negedge clk);
    psel = !alt; psel_alt = alt; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #2;
    d = alt ? prdata_alt : prdata;
    e = exp_rd(a);
    @(negedge clk);
    psel = 0; psel_alt = 0; penable = 0;
  endtask

  task automatic rd_model(input string tag, input logic [6:0] a);
    logic [31:0] d, e;
    apb_rd(1'b0, a, d, e);
    chk(tag, d, e);
  endtask

  task automatic rd_fixed(input string tag, input bit alt, input logic [6:0] a,
                          input logic [31:0] exp);
    logic [31:0] d, e;
    apb_rd(alt, a, d, e);
    chk(tag, d, exp);
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clocks(3);
    rst_n = 1;
    clocks(1);
    run_cmp = 1;

    // R1: reset values
    rd_fixed("R1 dr0", 0, 7'h00, 32'h0);
    rd_fixed("R1 en", 0, 7'h30, 32'h0);
    rd_fixed("R1 stat", 0, 7'h40, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2: output pairs per port
    for (int p = 0; p < NP; p++) begin
      apb_wr(0, 7'(12*p), 32'hA5A50000 | p);
      apb_wr(0, 7'(12*p + 4), 32'h0F0F0000 | (p << 4));
    end
    for (int p = 0; p < NP; p++) begin
      rd_fixed("R2 dr rb", 0, 7'(12*p), 32'hA5A50000 | p);
      rd_fixed("R2 ddr rb", 0, 7'(12*p + 4), 32'h0F0F0000 | (p << 4));
    end

    // R3: pin registers and two-flop latency
    pins = {32'hDEAD0003, 32'h12345678, 32'h00FF00FF, 32'h0};
    clocks(3);
    for (int p = 0; p < NP; p++) rd_model("R3 pin view", 7'(80 + 4*p));
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 0; paddr = 7'h54;
    pins[63:32] = 32'hCAFEF00D;
    @(negedge clk); #2;
    chk("R3 one edge old", prdata, 32'h00FF00FF);
    @(negedge clk); #2;
    chk("R3 two edges new", prdata, 32'hCAFEF00D);
    @(negedge clk);
    psel = 0; penable = 0;
    pins = '0;
    clocks(3);

    // R4: default interrupt map read back
    apb_wr(0, 7'h34, 32'h8000_0000);
    apb_wr(0, 7'h38, 32'h0000_0003);
    apb_wr(0, 7'h3c, 32'h0000_0005);
    apb_wr(0, 7'h48, 32'h0000_0000);
    rd_fixed("R4 mask", 0, 7'h34, 32'h8000_0000);
    rd_fixed("R4 type", 0, 7'h38, 32'h0000_0003);
    rd_fixed("R4 pol", 0, 7'h3c, 32'h0000_0005);
    rd_fixed("R4 clr reads 0", 0, 7'h4c, 32'h0);
    apb_wr(0, 7'h34, 32'h0);

    // R6: line0 rising edge, line1 falling edge
    pins[1] = 1'b1;
    clocks(4);
    apb_wr(0, 7'h30, 32'h0000_0003);
    pins[0] = 1'b1;
    clocks(4);
    pins[0] = 1'b0;
    clocks(4);
    rd_fixed("R6 rising latched", 0, 7'h40, 32'h1);
    apb_wr(0, 7'h4c, 32'h2);
    rd_fixed("R6 zero clr bit no effect", 0, 7'h40, 32'h1);
    apb_wr(0, 7'h4c, 32'h1);
    rd_fixed("R6 clr one", 0, 7'h40, 32'h0);
    pins[1] = 1'b0;
    clocks(4);
    rd_fixed("R6 falling latched", 0, 7'h40, 32'h2);
    apb_wr(0, 7'h4c, 32'hFFFF_FFFF);
    rd_fixed("R6 clear all", 0, 7'h40, 32'h0);

    // R7: level lines 2 (active high) and 3 (active low)
    apb_wr(0, 7'h3c, 32'h0000_0005);
    pins[3] = 1'b1;
    clocks(3);
    apb_wr(0, 7'h30, 32'h0000_000C);
    rd_fixed("R7 idle", 0, 7'h40, 32'h0);
    pins[2] = 1'b1;
    clocks(3);
    rd_fixed("R7 high active", 0, 7'h40, 32'h4);
    apb_wr(0, 7'h4c, 32'h4);
    rd_fixed("R7 clr ignored", 0, 7'h40, 32'h4);
    pins[2] = 1'b0; pins[3] = 1'b0;
    clocks(3);
    rd_fixed("R7 low active", 0, 7'h40, 32'h8);
    pins[3] = 1'b1;
    clocks(3);

    // R8: mask keeps latched edge, disable drops it
    apb_wr(0, 7'h30, 32'h1);
    apb_wr(0, 7'h34, 32'h1);
    pins[0] = 1'b1;
    clocks(4);
    pins[0] = 1'b0;
    rd_fixed("R8 masked hidden", 0, 7'h40, 32'h0);
    chk("R8 masked line", irq_line, 32'h0);
    apb_wr(0, 7'h34, 32'h0);
    rd_fixed("R8 unmask shows", 0, 7'h40, 32'h1);
    apb_wr(0, 7'h30, 32'h0);
    pins[0] = 1'b1;
    clocks(4);
    pins[0] = 1'b0;
    apb_wr(0, 7'h30, 32'h1);
    rd_fixed("R8 disable dropped", 0, 7'h40, 32'h0);

    // R10: filtered level line 4
    apb_wr(0, 7'h38, 32'h0000_0003);
    apb_wr(0, 7'h3c, 32'h0000_0015);
    apb_wr(0, 7'h48, 32'h0000_0010);
    apb_wr(0, 7'h30, 32'h0000_0010);
    clocks(10);
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 0; paddr = 7'h50;
    pins[4] = 1'b1;
    clocks(3); #2;
    chk("R10 raw pin view unfiltered", prdata & 32'h10, 32'h10);
    pins[4] = 1'b0;
    @(negedge clk);
    psel = 0; penable = 0;
    clocks(12);
    chk("R10 short pulse ignored", irq_line, 32'h0);
    pins[4] = 1'b1;
    clocks(16);
    chk("R10 long pulse seen", irq_line, 32'h10);
    pins[4] = 1'b0;
    clocks(16);
    chk("R10 release seen", irq_line, 32'h0);

    // R11: unmapped offsets
    rd_fixed("R11 gap 0x08", 0, 7'h08, 32'h0);
    rd_fixed("R11 gap 0x44", 0, 7'h44, 32'h0);
    rd_fixed("R11 gap 0x60", 0, 7'h60, 32'h0);
    apb_wr(0, 7'h08, 32'hFFFF_FFFF);
    rd_fixed("R11 write ignored", 0, 7'h00, 32'hA5A50000);
    apb_wr(1, 7'h18, 32'h1234_5678);
    rd_fixed("R11 absent port", 1, 7'h18, 32'h0);
    rd_fixed("R11 absent pin reg", 1, 7'h58, 32'h0);

    // R5: alternate map
    apb_wr(1, 7'h44, 32'h0000_0F00);
    apb_wr(1, 7'h34, 32'h0000_00F0);
    apb_wr(1, 7'h38, 32'h0000_0001);
    apb_wr(1, 7'h48, 32'h0000_0002);
    rd_fixed("R5 alt mask", 1, 7'h44, 32'h0000_0F00);
    rd_fixed("R5 alt type", 1, 7'h34, 32'h0000_00F0);
    rd_fixed("R5 alt pol", 1, 7'h38, 32'h0000_0001);
    rd_fixed("R5 alt filt", 1, 7'h48, 32'h0000_0002);
    apb_wr(1, 7'h30, 32'h0000_0001);
    pins_alt[0] = 1'b1;
    clocks(3);
    rd_fixed("R5 alt status", 1, 7'h3c, 32'h1);
    chk("R5 alt irq", {31'b0, irq_alt}, 32'h1);
    apb_wr(1, 7'h40, 32'h1);
    rd_fixed("R5 alt clr ignored on level", 1, 7'h3c, 32'h1);
    apb_wr(1, 7'h44, 32'h1);
    rd_fixed("R5 alt mask hides", 1, 7'h3c, 32'h0);

    clocks(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule